// File: doc/BRIEF.md
# Clock Mode Configuration Sequencer

This block keeps a packed 32-bit clock-mode word and drives it onto a clock generator through a safe switching order. Software changes one field at a time. Each field is given as a plain ratio or value, and the block turns it into the stored code. The fields are PLL enable, input divider, VCO multiplier, post divider, crystal load and source. The word that the generator sees is a registered output, `applied_word`. The oscillator, the PLL and the glitch-free clock mux that would consume it are not part of this block.

Source changes arrive as commands. Either internal RC source is taken at once: the generator gets only the source code and the stored word is cleared. A crystal or PLL command works in two steps. First the stored word is applied with its current source bits, so the oscillator and PLL can start while the old clock is still running. After a settle interval the new source code is written into the low bits and the word is applied a second time. While this runs, the block reports busy and turns away any write or command with an error pulse.

From the applied word the block also derives the PLL multiply and divide ratio as a numerator and denominator pair. The pair is flagged valid only while the applied source is the PLL.

The control unit is a three-state machine:
- **IDLE** accepts field writes and commands. A crystal or PLL command performs the first apply and moves to **SETTLE**.
- **SETTLE** counts `SETTLE_CYC` cycles, then moves to **COMMIT**.
- **COMMIT** writes the pending source into the stored word, performs the final apply and returns to **IDLE**.

Top module: `clkcfg_seq`

## Requirements
- R1: After reset `applied_word` and `cfg_word` are zero (fast RC source), and `busy` and `err` are low.
- R2: Input divider writes (`fld_sel`=1) take a ratio from 1 to 64 and store ratio−1 in bits 23:18. VCO multiplier writes (`fld_sel`=2) take a ratio from 1 to 1024 and store ratio−1 modulo 1024 in bits 17:8.
- R3: Post divider writes (`fld_sel`=3) take ratio 1 or an even ratio from 2 to 30 and store it in bits 7:4. An even ratio r is stored as r/2−1, and ratio 1 is stored as code 15.
- R4: PLL enable writes (`fld_sel`=0) store `fld_val[0]` in bit 24. Crystal load writes (`fld_sel`=4) store `fld_val[1:0]` in bits 3:2 (0 unused, 1 none, 2 15 pF, 3 30 pF). Bits 31:25 stay zero.
- R5: A field write is a read-modify-write. It changes only that field, and `cfg_word` shows the result one cycle after the write.
- R6: An idle command with `cmd_src` 0 (fast RC) or 1 (slow RC) sets, one cycle later, `applied_word` to the source code alone and `cfg_word` to zero. `busy` stays low.
- R7: An idle command with `cmd_src` 2 (crystal) or 3 (PLL) sets, one cycle later, `applied_word` to `cfg_word` as it stood, source bits unchanged, and raises `busy`.
- R8: Exactly `SETTLE_CYC`+1 cycles after the first apply, bits 1:0 of both words take the new source and `applied_word` equals `cfg_word`. `busy` falls in that same cycle, and `applied_word` holds steady in between.
- R9: While `busy`, any field write or command is ignored and `err` pulses high for one cycle, the cycle after.
- R10: A command and a field write in the same idle cycle: the command is taken, the write is dropped, and `err` pulses.
- R11: `ratio_mul` is the applied multiplier code +1. `ratio_div` is (input divider code +1) × post divide ratio, with code 15 meaning 1 and code c meaning 2c+2. `ratio_valid` is high only while the applied source bits are 3.
- R12: A field write with `fld_sel` 5, 6 or 7 leaves `cfg_word` unchanged and raises no `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fld_we | input | 1 | Field write strobe |
| fld_sel | input | 3 | Field select: 0 PLL enable, 1 input divider, 2 multiplier, 3 post divider, 4 crystal load |
| fld_val | input | 11 | Ratio or value for the selected field |
| cmd_valid | input | 1 | Source command strobe |
| cmd_src | input | 2 | Requested source: 0 fast RC, 1 slow RC, 2 crystal, 3 PLL |
| cfg_word | output | 32 | Stored configuration word |
| applied_word | output | 32 | Word currently driven to the clock generator |
| busy | output | 1 | Crystal/PLL switch in progress |
| err | output | 1 | One-cycle pulse on a refused write or command |
| ratio_mul | output | 11 | PLL multiply ratio |
| ratio_div | output | 12 | PLL total divide ratio (input × post) |
| ratio_valid | output | 1 | Applied source is the PLL |

## Verification
Field writes, RC commands, the first apply and `err` all show one cycle after the edge that samples the stimulus. The final apply and the fall of `busy` come `SETTLE_CYC`+1 cycles after the first apply. The ratio outputs follow `applied_word` within the same cycle. The bench drives inputs on the falling edge and advances a behavioural model on each rising edge with the same inputs. On every falling edge it compares all outputs against that model, so each result is checked in exactly the cycle it is due. This is backed by literal checks of field codes and of the reset state.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
    localparam int WORD_W    = 32;
    localparam int PLLEN_BIT = 24;
    localparam int IDIV_LSB  = 18;
    localparam int IDIV_W    = 6;
    localparam int VMUL_LSB  = 8;
    localparam int VMUL_W    = 10;
    localparam int PDIV_LSB  = 4;
    localparam int PDIV_W    = 4;
    localparam int XLD_LSB   = 2;
    localparam int XLD_W     = 2;
    localparam int SRC_W     = 2;
    localparam int SEL_W     = 3;
    localparam int VAL_W     = VMUL_W + 1;
    localparam int RMUL_W    = VMUL_W + 1;
    localparam int PRAT_W    = PDIV_W + 1;
    localparam int RDIV_W    = (IDIV_W + 1) + PRAT_W;

    typedef enum logic [SRC_W-1:0] {
        SRC_RCFAST = 2'd0,
        SRC_RCSLOW = 2'd1,
        SRC_XTAL   = 2'd2,
        SRC_PLL    = 2'd3
    } clk_src_e;

    typedef enum logic [SEL_W-1:0] {
        FS_PLLEN = 3'd0,
        FS_IDIV  = 3'd1,
        FS_VMUL  = 3'd2,
        FS_PDIV  = 3'd3,
        FS_XLOAD = 3'd4
    } fld_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_COMMIT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/clkcfg_field_enc.sv
module clkcfg_field_enc
    import clkcfg_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic [VAL_W-1:0]  val,
    output logic [WORD_W-1:0] mask,
    output logic [WORD_W-1:0] bits,
    output logic              legal
);
    fld_sel_e         sel_e;
    logic [VAL_W-1:0] val_m1;
    logic [PDIV_W-1:0] half_m1;
    logic             unused_hi;

    assign sel_e     = fld_sel_e'(sel);
    assign val_m1    = val - 1'b1;
    assign half_m1   = val[PDIV_W:1] - 1'b1;
    assign unused_hi = val_m1[VAL_W-1] ^ (^val[VAL_W-1:PDIV_W+1]);

    always_comb begin
        mask  = '0;
        bits  = '0;
        legal = 1'b1;
        case (sel_e)
            FS_PLLEN: begin
                mask[PLLEN_BIT] = 1'b1;
                bits[PLLEN_BIT] = val[0];
            end
            FS_IDIV: begin
                mask[IDIV_LSB +: IDIV_W] = '1;
                bits[IDIV_LSB +: IDIV_W] = val_m1[IDIV_W-1:0];
            end
            FS_VMUL: begin
                mask[VMUL_LSB +: VMUL_W] = '1;
                bits[VMUL_LSB +: VMUL_W] = val_m1[VMUL_W-1:0];
            end
            FS_PDIV: begin
                mask[PDIV_LSB +: PDIV_W] = '1;
                bits[PDIV_LSB +: PDIV_W] = half_m1;
            end
            FS_XLOAD: begin
                mask[XLD_LSB +: XLD_W] = '1;
                bits[XLD_LSB +: XLD_W] = val[XLD_W-1:0];
            end
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/clkcfg_word_reg.sv
module clkcfg_word_reg
    import clkcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_mask,
    input  logic [WORD_W-1:0] wr_bits,
    input  logic              clr,
    input  logic              src_wr,
    input  logic [SRC_W-1:0]  src_val,
    output logic [WORD_W-1:0] cfg
);
    logic [WORD_W-1:0] cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (clr) begin
            cfg_q <= '0;
        end else if (src_wr) begin
            cfg_q[SRC_W-1:0] <= src_val;
        end else if (wr_en) begin
            cfg_q <= (cfg_q & ~wr_mask) | wr_bits;
        end
    end

    assign cfg = cfg_q;

    // R5: bits outside the written field keep their value
    assert_rmw_keeps_others_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr && !src_wr) |=> ((cfg_q & ~$past(wr_mask)) == ($past(cfg_q) & ~$past(wr_mask))));
endmodule

// File: rtl/clkcfg_seq_ctrl.sv
module clkcfg_seq_ctrl
    import clkcfg_pkg::*;
#(
    parameter int SETTLE_CYC = 200000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fld_we,
    input  logic              fld_legal,
    input  logic              cmd_valid,
    input  logic [SRC_W-1:0]  cmd_src,
    input  logic [WORD_W-1:0] cfg_word,
    output logic              fld_take,
    output logic              cfg_clear,
    output logic              src_commit,
    output logic [SRC_W-1:0]  src_pend,
    output logic [WORD_W-1:0] applied_word,
    output logic              busy,
    output logic              err
);
    localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [SRC_W-1:0]  pend_q;
    logic [WORD_W-1:0] applied_q;
    logic              err_q;
    logic              idle, cmd_take, rc_take, slow_take, settle_done, refuse;

    assign idle        = (state_q == ST_IDLE);
    assign cmd_take    = idle && cmd_valid;
    assign rc_take     = cmd_take && !cmd_src[1];
    assign slow_take   = cmd_take && cmd_src[1];
    assign settle_done = (cnt_q == CNT_LAST);
    assign refuse      = (!idle && (fld_we || cmd_valid)) || (cmd_take && fld_we);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (slow_take) state_d = ST_SETTLE;
            ST_SETTLE: if (settle_done) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            pend_q    <= SRC_RCFAST;
            applied_q <= '0;
            err_q     <= 1'b0;
        end else begin
            err_q <= refuse;
            unique case (state_q)
                ST_IDLE: begin
                    if (rc_take) begin
                        applied_q <= {{(WORD_W-SRC_W){1'b0}}, cmd_src};
                    end else if (slow_take) begin
                        applied_q <= cfg_word;
                        pend_q    <= cmd_src;
                        cnt_q     <= '0;
                    end
                end
                ST_SETTLE: begin
                    if (!settle_done) cnt_q <= cnt_q + 1'b1;
                end
                ST_COMMIT: begin
                    applied_q <= {cfg_word[WORD_W-1:SRC_W], pend_q};
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    assign fld_take     = idle && fld_we && !cmd_valid && fld_legal;
    assign cfg_clear    = rc_take;
    assign src_commit   = (state_q == ST_COMMIT);
    assign src_pend     = pend_q;
    assign applied_word = applied_q;
    assign busy         = !idle;
    assign err          = err_q;

    // R7: first apply copies the stored word and the sequence starts
    assert_first_apply_R7: assert property (@(posedge clk) disable iff (!rst_n)
        slow_take |=> (state_q == ST_SETTLE && applied_q == $past(cfg_word)));

    // R8: the applied word is held during settling
    assert_settle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE) |=> $stable(applied_q));

    // R8: the commit lands on a crystal or PLL source and ends the sequence
    assert_commit_slow_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |=> (state_q == ST_IDLE && applied_q[1]));
endmodule

// File: rtl/clkcfg_ratio.sv
module clkcfg_ratio
    import clkcfg_pkg::*;
(
    input  logic [IDIV_W-1:0] idiv_code,
    input  logic [VMUL_W-1:0] vmul_code,
    input  logic [PDIV_W-1:0] pdiv_code,
    input  logic [SRC_W-1:0]  src,
    output logic [RMUL_W-1:0] ratio_mul,
    output logic [RDIV_W-1:0] ratio_div,
    output logic              ratio_valid
);
    logic [PRAT_W-1:0] post_ratio;
    logic [RDIV_W-1:0] idiv_ratio;

    assign post_ratio  = (pdiv_code == '1) ? PRAT_W'(1) : ({1'b0, pdiv_code} + 1'b1) << 1;
    assign idiv_ratio  = RDIV_W'(idiv_code) + 1'b1;
    assign ratio_mul   = RMUL_W'(vmul_code) + 1'b1;
    assign ratio_div   = idiv_ratio * RDIV_W'(post_ratio);
    assign ratio_valid = (src == SRC_PLL);
endmodule

// File: rtl/clkcfg_seq.sv
module clkcfg_seq
    import clkcfg_pkg::*;
#(
    parameter int SETTLE_CYC = 200000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fld_we,
    input  logic [2:0]  fld_sel,
    input  logic [10:0] fld_val,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_src,
    output logic [31:0] cfg_word,
    output logic [31:0] applied_word,
    output logic        busy,
    output logic        err,
    output logic [10:0] ratio_mul,
    output logic [11:0] ratio_div,
    output logic        ratio_valid
);
    logic [WORD_W-1:0] enc_mask, enc_bits, cfg_w, app_w;
    logic              enc_legal, fld_take, cfg_clear, src_commit;
    logic [SRC_W-1:0]  src_pend;

    clkcfg_field_enc u_enc (
        .sel   (fld_sel),
        .val   (fld_val),
        .mask  (enc_mask),
        .bits  (enc_bits),
        .legal (enc_legal)
    );

    clkcfg_word_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fld_take),
        .wr_mask (enc_mask),
        .wr_bits (enc_bits),
        .clr     (cfg_clear),
        .src_wr  (src_commit),
        .src_val (src_pend),
        .cfg     (cfg_w)
    );

    clkcfg_seq_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .fld_we       (fld_we),
        .fld_legal    (enc_legal),
        .cmd_valid    (cmd_valid),
        .cmd_src      (cmd_src),
        .cfg_word     (cfg_w),
        .fld_take     (fld_take),
        .cfg_clear    (cfg_clear),
        .src_commit   (src_commit),
        .src_pend     (src_pend),
        .applied_word (app_w),
        .busy         (busy),
        .err          (err)
    );

    clkcfg_ratio u_ratio (
        .idiv_code   (app_w[IDIV_LSB +: IDIV_W]),
        .vmul_code   (app_w[VMUL_LSB +: VMUL_W]),
        .pdiv_code   (app_w[PDIV_LSB +: PDIV_W]),
        .src         (app_w[SRC_W-1:0]),
        .ratio_mul   (ratio_mul),
        .ratio_div   (ratio_div),
        .ratio_valid (ratio_valid)
    );

    assign cfg_word     = cfg_w;
    assign applied_word = app_w;

    // R9: a write during a switch is refused and leaves the word alone
    assert_busy_refuses_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fld_we) |=> (err && $stable(cfg_word)));

    // R6: RC command clears the word and applies the bare source code
    assert_rc_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && !cmd_src[1]) |=>
            (cfg_word == '0 && applied_word[1:0] == $past(cmd_src) && !busy));

    // R8: when the switch completes both words agree
    assert_final_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (applied_word == cfg_word));
endmodule

// File: tb/clkcfg_seq_test.sv
module clkcfg_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fld_we = 1'b0;
    logic [2:0]  fld_sel = '0;
    logic [10:0] fld_val = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_src = '0;
    logic [31:0] cfg_word, applied_word;
    logic        busy, err, ratio_valid;
    logic [10:0] ratio_mul;
    logic [11:0] ratio_div;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";

    clkcfg_seq #(.SETTLE_CYC(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .fld_we(fld_we), .fld_sel(fld_sel), .fld_val(fld_val),
        .cmd_valid(cmd_valid), .cmd_src(cmd_src), .cfg_word(cfg_word),
        .applied_word(applied_word), .busy(busy), .err(err),
        .ratio_mul(ratio_mul), .ratio_div(ratio_div), .ratio_valid(ratio_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    logic [31:0] m_cfg = '0, m_app = '0;
    bit m_busy = 0, m_err = 0;
    int m_cnt = 0, m_pend = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = '0; m_app = '0; m_busy = 0; m_err = 0; m_cnt = 0;
        end else begin
            m_err = 0;
            if (m_busy) begin
                if (fld_we || cmd_valid) m_err = 1;
                m_cnt++;
                if (m_cnt == SETTLE + 1) begin
                    m_cfg[1:0] = 2'(m_pend);
                    m_app = m_cfg;
                    m_busy = 0;
                end
            end else if (cmd_valid) begin
                if (fld_we) m_err = 1;
                if (cmd_src < 2) begin
                    m_cfg = '0;
                    m_app = 32'(cmd_src);
                end else begin
                    m_app = m_cfg; m_pend = int'(cmd_src); m_busy = 1; m_cnt = 0;
                end
            end else if (fld_we) begin
                case (fld_sel)
                    3'd0: m_cfg[24] = fld_val[0];
                    3'd1: m_cfg[23:18] = 6'((int'(fld_val) - 1) & 63);
                    3'd2: m_cfg[17:8] = 10'((int'(fld_val) - 1) & 1023);
                    3'd3: m_cfg[7:4] = (fld_val == 1) ? 4'd15 : 4'((int'(fld_val) / 2 - 1) & 15);
                    3'd4: m_cfg[3:2] = fld_val[1:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            int post, mul, dv;
            chk(cfg_word == m_cfg, cur_req, "cfg_word", cfg_word, m_cfg);
            chk(applied_word == m_app, cur_req, "applied_word", applied_word, m_app);
            chk(busy == m_busy, cur_req, "busy", 32'(busy), 32'(m_busy));
            chk(err == m_err, "R9", "err", 32'(err), 32'(m_err));
            chk(ratio_valid == (m_app[1:0] == 2'd3), "R11", "ratio_valid",
                32'(ratio_valid), 32'(m_app[1:0] == 2'd3));
            mul  = int'(m_app[17:8]) + 1;
            post = (m_app[7:4] == 4'd15) ? 1 : 2 * (int'(m_app[7:4]) + 1);
            dv   = (int'(m_app[23:18]) + 1) * post;
            chk(int'(ratio_mul) == mul, "R11", "ratio_mul", 32'(ratio_mul), 32'(mul));
            chk(int'(ratio_div) == dv, "R11", "ratio_div", 32'(ratio_div), 32'(dv));
        end
    end

    task automatic wr_field(input logic [2:0] s, input logic [10:0] v);
        @(negedge clk);
        fld_we = 1'b1; fld_sel = s; fld_val = v;
        @(negedge clk);
        fld_we = 1'b0;
    endtask

    task automatic send_cmd(input logic [1:0] s);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_src = s;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired (R8) actual=%0d expected=0", 1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(applied_word == 32'h0 && cfg_word == 32'h0, "R1", "words at reset",
            applied_word ^ cfg_word, 32'h0);
        chk(!busy && !err, "R1", "busy/err at reset", {30'h0, busy, err}, 32'h0);
        rst_n = 1'b1;
        idle_cycles(2);

        cur_req = "R2";
        wr_field(3'd1, 11'd12);
        chk(cfg_word[23:18] == 6'd11, "R2", "idiv code for 12", 32'(cfg_word[23:18]), 32'd11);
        wr_field(3'd2, 11'd1024);
        chk(cfg_word[17:8] == 10'd1023, "R2", "vmul code for 1024", 32'(cfg_word[17:8]), 32'd1023);
        wr_field(3'd1, 11'd64);
        wr_field(3'd1, 11'd1);
        wr_field(3'd2, 11'd15);

        cur_req = "R3";
        wr_field(3'd3, 11'd1);
        chk(cfg_word[7:4] == 4'd15, "R3", "pdiv code for 1", 32'(cfg_word[7:4]), 32'd15);
        wr_field(3'd3, 11'd30);
        chk(cfg_word[7:4] == 4'd14, "R3", "pdiv code for 30", 32'(cfg_word[7:4]), 32'd14);
        wr_field(3'd3, 11'd2);

        cur_req = "R4";
        wr_field(3'd0, 11'd1);
        chk(cfg_word[24], "R4", "pll enable bit", 32'(cfg_word[24]), 32'd1);
        wr_field(3'd4, 11'd3);
        chk(cfg_word[31:25] == 7'd0, "R4", "upper bits zero", 32'(cfg_word[31:25]), 32'd0);

        cur_req = "R5";
        wr_field(3'd1, 11'd4);
        chk(cfg_word[17:8] == 10'd14 && cfg_word[3:2] == 2'd3, "R5", "other fields kept",
            32'(cfg_word[17:0]), {14'h0, 10'd14, 8'h0C} | (cfg_word[7:4] << 4));

        cur_req = "R12";
        wr_field(3'd6, 11'd7);
        chk(!err, "R12", "no err on bad select", 32'(err), 32'd0);

        // PLL switch with refused traffic in the middle
        cur_req = "R7";
        send_cmd(2'd3);
        chk(busy, "R7", "busy after PLL command", 32'(busy), 32'd1);
        cur_req = "R9";
        wr_field(3'd2, 11'd100);
        send_cmd(2'd1);
        cur_req = "R8";
        idle_cycles(SETTLE + 4);
        chk(applied_word[1:0] == 2'd3 && ratio_valid, "R8", "PLL applied",
            32'(applied_word[1:0]), 32'd3);

        cur_req = "R6";
        send_cmd(2'd1);
        chk(cfg_word == 0 && applied_word == 32'd1, "R6", "slow RC apply", applied_word, 32'd1);

        cur_req = "R10";
        wr_field(3'd4, 11'd2);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_src = 2'd2; fld_we = 1'b1; fld_sel = 3'd1; fld_val = 11'd8;
        @(negedge clk);
        cmd_valid = 1'b0; fld_we = 1'b0;
        chk(err && busy, "R10", "command wins with err", {30'h0, err, busy}, 32'd3);
        cur_req = "R8";
        idle_cycles(SETTLE + 4);
        chk(applied_word == 32'h0000_000A, "R8", "crystal applied", applied_word, 32'h0000_000A);

        cur_req = "R6";
        send_cmd(2'd0);
        idle_cycles(2);

        summary();
        $finish;
    end
endmodule